// File: doc/BRIEF.md
# Two-Level Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short register of the most recent resolved branch outcomes across the whole program. It also keeps a table of small saturating counters. Each group of counters in the table is reached through a few low bits of the branch address. Within that group, the outcome history picks one counter. The most significant bit of that counter is the prediction.

Fetch logic presents a branch address on the lookup port and gets a direction back combinationally in the same cycle. When the branch resolves later, the execute stage presents the address and the real outcome on the update port. On that clock edge the selected counter moves one step toward the outcome. The outcome is then shifted into the history. Address bits outside the index are never compared, so two branches that share index bits share counters.

Top module: `corr_bp`

## Requirements
- R1: While `rst_n` is low at a clock edge, every counter is set to the weakly not-taken value 01 and the history is set to 00. After reset, every lookup therefore predicts not taken.
- R2: `lk_taken` is a combinational function of `lk_pc` and the stored state, valid in the same cycle. The group is chosen by `lk_pc[5:2]`, which gives 16 groups.
- R3: Each group holds four counters. The counter index is `{pc[5:2], hist[1:0]}`, so the history picks one counter of the four.
- R4: The prediction is taken exactly when the selected counter is 2 or 3. An accepted taken update adds one, up to a ceiling of 3. An accepted not-taken update subtracts one, down to a floor of 0.
- R5: A counter at 3 or 0 needs two opposite outcomes before its prediction flips. One opposite outcome leaves the prediction unchanged.
- R6: An accepted update changes only the counter at `{up_pc[5:2], hist}`. It uses the history as it stood before that edge, and every other counter keeps its value.
- R7: On the same edge as an accepted update, the history becomes `{hist[0], up_taken}`. Bit 0 holds the newest outcome and bit 1 the one before it, so 01 means the older branch was not taken and the newer one was taken.
- R8: No tag is stored or compared. Addresses that differ only outside bits [5:2] give identical predictions and train the same counters.
- R9: When `up_valid` is low, no counter and no history bit changes, whatever `up_pc` and `up_taken` carry.
- R10: A lookup in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Branch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 means taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 means taken |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 2 alignment bits, 4 index bits, 2 history bits and 2-bit counters, which gives 64 counters. With this configuration, every lookup check can sweep all 16 groups under the current history. Each sweep is repeated with different upper address bits to exercise aliasing. Directed sequences steer the history through each of its four values so that individual counters can be reached. They also drive counters into saturation and back again to show hysteresis. A long run of random updates then compares every group against an arithmetic model after each edge.

// File: rtl/corr_bp_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the correlating predictor.
// Assumes counters are unsigned and at least one bit wide.
package corr_bp_pkg;

    // Move a saturating counter one step toward the resolved outcome.
    function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                            input logic       taken,
                                            input int unsigned width);
        logic [7:0] top;
        top = 8'((1 << width) - 1);
        if (taken)
            sat_step = (cur == top) ? cur : cur + 8'd1;
        else
            sat_step = (cur == 8'd0) ? cur : cur - 8'd1;
    endfunction

    // Reset value: one step below the taken threshold (weakly not-taken).
    function automatic logic [7:0] weak_nt(input int unsigned width);
        weak_nt = 8'((1 << (width - 1)) - 1);
    endfunction

endpackage

// File: rtl/corr_ghist.sv
`timescale 1ns/1ps
// Global outcome history register.
// Shifts the resolved outcome into bit 0 on each accepted update; bit 0 is
// always the newest outcome. Assumes HIST_W >= 1.
module corr_ghist #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;

    generate
        if (HIST_W == 1) begin : g_one
            // Single-bit history: newest outcome replaces the old one.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= shift_bit;
            end
        end else begin : g_many
            // Multi-bit history: age the older bits up and insert the newest at bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
            end
        end
    endgenerate

    assign hist_o = hist_q;

endmodule

// File: rtl/corr_idx.sv
`timescale 1ns/1ps
// Counter index builder.
// Joins the selected address bits (upper part) and the history (lower part)
// into a flat counter index. Assumes PC_LSB + ENT_BITS <= PC_W.
module corr_idx #(
    parameter int PC_W     = 32,
    parameter int PC_LSB   = 2,
    parameter int ENT_BITS = 4,
    parameter int HIST_W   = 2,
    localparam int IDX_W   = ENT_BITS + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    // Address bits outside the slice do not take part: no tag is kept.
    logic unused_pc_bits;
    assign unused_pc_bits = ^pc;

    // Group from the address, member from the history.
    always_comb begin
        idx = {pc[PC_LSB +: ENT_BITS], hist};
    end

endmodule

// File: rtl/corr_ctr_cell.sv
`timescale 1ns/1ps
// One saturating direction counter.
// Steps toward the outcome when its update enable is high and holds otherwise.
// Assumes CTR_W is between 1 and 8.
module corr_ctr_cell #(
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic             upd_taken,
    output logic [CTR_W-1:0] cnt_o
);
    import corr_bp_pkg::*;

    logic [CTR_W-1:0] cnt_q;
    logic [CTR_W-1:0] cnt_d;
    logic [7:0]       stepped;

    // Next value when this cell is the one selected for update.
    always_comb begin
        stepped = sat_step(8'(cnt_q), upd_taken, CTR_W);
        cnt_d   = upd_en ? stepped[CTR_W-1:0] : cnt_q;
    end

    // State register with reset to weakly not-taken.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CTR_W'(weak_nt(CTR_W));
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/corr_bp.sv
`timescale 1ns/1ps
// Two-level correlating branch direction predictor (top).
// Lookup is combinational from the current state. An update trains the
// counter chosen by the pre-edge history, then shifts the outcome into the
// history on the same edge. Assumes one update per cycle at most.
module corr_bp #(
    parameter int PC_W     = 32,
    parameter int PC_LSB   = 2,
    parameter int ENT_BITS = 4,
    parameter int HIST_W   = 2,
    parameter int CTR_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    localparam int IDX_W = ENT_BITS + HIST_W;
    localparam int N_CTR = 1 << IDX_W;

    logic [HIST_W-1:0]           ghist_q;
    logic [IDX_W-1:0]            lk_idx;
    logic [IDX_W-1:0]            up_idx;
    logic [N_CTR-1:0][CTR_W-1:0] ctr_q;

    // Index for the lookup side.
    corr_idx #(.PC_W(PC_W), .PC_LSB(PC_LSB), .ENT_BITS(ENT_BITS), .HIST_W(HIST_W))
        u_lk_idx (.pc(lk_pc), .hist(ghist_q), .idx(lk_idx));

    // Index for the update side, built from the history before the shift.
    corr_idx #(.PC_W(PC_W), .PC_LSB(PC_LSB), .ENT_BITS(ENT_BITS), .HIST_W(HIST_W))
        u_up_idx (.pc(up_pc), .hist(ghist_q), .idx(up_idx));

    // Outcome history.
    corr_ghist #(.HIST_W(HIST_W))
        u_hist (.clk(clk), .rst_n(rst_n), .shift_en(up_valid),
                .shift_bit(up_taken), .hist_o(ghist_q));

    // Counter array: one cell per (group, history) pair.
    generate
        for (genvar i = 0; i < N_CTR; i++) begin : g_cell
            logic hit;
            assign hit = up_valid && (up_idx == IDX_W'(i));
            corr_ctr_cell #(.CTR_W(CTR_W))
                u_cell (.clk(clk), .rst_n(rst_n), .upd_en(hit),
                        .upd_taken(up_taken), .cnt_o(ctr_q[i]));
        end
    endgenerate

    // Prediction is the top bit of the selected counter.
    always_comb begin
        lk_taken = ctr_q[lk_idx][CTR_W-1];
    end

endmodule

// File: rtl/corr_bp_chk.sv
`timescale 1ns/1ps
// Assertion checker for corr_bp, attached by bind.
// Observes the update request, the history and the whole counter array.
module corr_bp_chk #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 2,
    parameter int CTR_W  = 2,
    parameter int N_CTR  = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      up_valid,
    input logic                      up_taken,
    input logic [IDX_W-1:0]          up_idx,
    input logic [HIST_W-1:0]         ghist,
    input logic [N_CTR-1:0][CTR_W-1:0] ctr_q
);

    localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] ONE  = {{(CTR_W-1){1'b0}}, 1'b1};

    // R7: accepted update shifts the outcome in as the newest bit.
    p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> ghist == HIST_W'({$past(ghist), $past(up_taken)}));

    // R9: no update leaves history untouched.
    p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ghist));

    // R9: no update leaves every counter untouched.
    p_ctr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ctr_q));

    // R4: taken below the ceiling steps up by one.
    p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && ctr_q[up_idx] != CMAX)
        |=> ctr_q[$past(up_idx)] == $past(ctr_q[up_idx]) + ONE);

    // R4: taken at the ceiling stays there.
    p_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && ctr_q[up_idx] == CMAX)
        |=> ctr_q[$past(up_idx)] == CMAX);

    // R4: not-taken above the floor steps down by one.
    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && ctr_q[up_idx] != '0)
        |=> ctr_q[$past(up_idx)] == $past(ctr_q[up_idx]) - ONE);

    // R4: not-taken at the floor stays there.
    p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && ctr_q[up_idx] == '0)
        |=> ctr_q[$past(up_idx)] == '0);

endmodule

bind corr_bp corr_bp_chk #(
    .IDX_W(IDX_W), .HIST_W(HIST_W), .CTR_W(CTR_W), .N_CTR(N_CTR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken),
    .up_idx(up_idx), .ghist(ghist_q), .ctr_q(ctr_q)
);

// File: tb/corr_bp_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: arithmetic model of 64 counters and a 2-bit history.
module corr_bp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_taken;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int mctr [64];
    int mh = 0;

    always #2.5 clk = ~clk;

    corr_bp dut_i (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
                   .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    function automatic logic [31:0] mk_pc(input int ent);
        logic [31:0] r;
        r = $urandom;
        r[5:2] = ent[3:0];
        return r;
    endfunction

    function automatic bit mpred(input int ent);
        return mctr[ent * 4 + mh] >= 2;
    endfunction

    task automatic chk(input bit got, input bit exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: lk_taken=%0b expected=%0b hist=%0d t=%0t",
                     req, got, exp, mh, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) mctr[i] = 1;
        mh = 0;
    endtask

    // Sweep all 16 groups twice with different upper address bits (R2, R3, R8).
    task automatic sweep(input string req);
        @(negedge clk);
        for (int e = 0; e < 16; e++) begin
            lk_pc = mk_pc(e);
            #0.05;
            chk(lk_taken, mpred(e), req);
            lk_pc = mk_pc(e);
            #0.05;
            chk(lk_taken, mpred(e), "R8");
        end
    endtask

    // One accepted update; a same-cycle lookup must see old state (R10).
    task automatic upd(input int ent, input bit t);
        int k;
        @(negedge clk);
        up_pc = mk_pc(ent);
        up_taken = t;
        up_valid = 1'b1;
        lk_pc = mk_pc(ent);
        #0.5;
        chk(lk_taken, mpred(ent), "R10");
        @(posedge clk);
        k = ent * 4 + mh;
        if (t) mctr[k] = (mctr[k] == 3) ? 3 : mctr[k] + 1;
        else   mctr[k] = (mctr[k] == 0) ? 0 : mctr[k] - 1;
        mh = ((mh << 1) | int'(t)) & 3;
        #0.5;
        up_valid = 1'b0;
    endtask

    task automatic lookup_exp(input int ent, input bit exp, input string req);
        @(negedge clk);
        lk_pc = mk_pc(ent);
        #0.5;
        chk(lk_taken, exp, req);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        report();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        sweep("R1");

        // R3/R7: train {7,00} only, then history order decides what is seen.
        upd(7, 1'b1);                 // {7,00}=2, hist=01
        lookup_exp(7, 1'b0, "R3");    // {7,01} still 1
        upd(9, 1'b0);                 // hist=10
        upd(9, 1'b0);                 // hist=00
        lookup_exp(7, 1'b1, "R7");    // back on {7,00}=2
        upd(4, 1'b1);                 // hist=01 (older NT, newer T)
        lookup_exp(7, 1'b0, "R7");
        sweep("R6");

        // R4/R5: saturate {3,11}, one miss keeps taken, second miss flips.
        repeat (6) upd(3, 1'b1);      // hist=11, {3,11}=3
        lookup_exp(3, 1'b1, "R4");
        upd(3, 1'b0);                 // {3,11}=2, hist=10
        upd(5, 1'b1);                 // hist=01
        upd(5, 1'b1);                 // hist=11
        lookup_exp(3, 1'b1, "R5");
        upd(3, 1'b0);                 // {3,11}=1, hist=10
        upd(5, 1'b1);
        upd(5, 1'b1);                 // hist=11
        lookup_exp(3, 1'b0, "R5");
        sweep("R4");

        // R5 low side: drive {12,00} to 0, one taken must not flip it.
        repeat (4) upd(12, 1'b0);     // hist=00, {12,00}=0
        upd(12, 1'b1);                // {12,00}=1, hist=01
        upd(1, 1'b0);
        upd(1, 1'b0);                 // hist=00
        lookup_exp(12, 1'b0, "R5");

        // R9: garbage on update side with valid low.
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            up_pc = $urandom;
            up_taken = 1'(i);
            @(negedge clk);
        end
        sweep("R9");

        // R2/R6: random traffic with a full sweep after each update.
        for (int i = 0; i < 400; i++) begin
            upd(int'($urandom_range(0, 15)), 1'($urandom));
            sweep("R6");
        end

        // R1: reset again after training.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #0.5 rst_n = 1'b1;
        model_reset();
        sweep("R1");

        report();
    end

endmodule